// File: doc/BRIEF.md
# Single-Outstanding Line Memory with Fixed Latency

This block models a line-wide memory that sits behind a command channel and finishes each command after a fixed number of cycles. It holds at most one command at a time. A requester offers a command with a valid/ready handshake. The command either writes one line or reads one line. The block accepts a command only when it holds none. It then counts down a latency fixed at elaboration, and the command completes when the count runs out.

A write completes by updating the addressed line and gives no reply. A read completes by placing the line and its line address into a one-entry response slot, which drains under its own valid/ready handshake. While that slot is full and not draining, a read whose countdown has expired keeps waiting, and the command channel stays closed. Every line reads as zero until it is first written. The line is `LINE_WORDS` words of `WORD_W` bits, with word 0 in the least significant bits.

Top module: `linemem_single`

## Requirements
- R1: After reset `cmd_ready` is 1 and `rsp_valid` is 0, and `cmd_ready` is 1 in every cycle in which no command is held.
- R2: Only one command is held at a time. Once a command is accepted (`cmd_valid && cmd_ready` at a rising edge) and does not complete at that same edge, `cmd_ready` is 0 until the edge at which the command completes.
- R3: With `LATENCY` = L > 0, a write accepted at edge E0 completes at edge E0+L. It stores `cmd_wdata` into line `cmd_addr`, it raises `cmd_ready` again after that edge, and it never raises `rsp_valid`.
- R4: With `LATENCY` = L > 0 and a free response slot, a read accepted at edge E0 completes at edge E0+L. After that edge `rsp_valid` is 1, `rsp_data` holds the current content of the line, and `rsp_addr` equals the `cmd_addr` that was accepted.
- R5: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` and `rsp_addr` stay stable. A read whose countdown has expired keeps waiting, with `cmd_ready` 0. At the edge where the pending response is taken, the waiting read's line moves into the slot.
- R6: A line that has never been written reads back as all zeros.
- R7: With `LATENCY` = 0, a command completes at the very edge at which it is accepted. A write leaves `cmd_ready` at 1, and a read shows `rsp_valid` right after the accepting edge.
- R8: A response leaves the slot at the edge where `rsp_valid && rsp_ready`. If no new read completes at that edge, `rsp_valid` is 0 afterwards.
- R9: While the countdown is still running, no line is written and no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears state and all lines |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block holds no command and will take one |
| cmd_write | input | 1 | 1 = write line, 0 = read line |
| cmd_addr | input | $clog2(DEPTH) | Line address |
| cmd_wdata | input | WORD_W*LINE_WORDS | Line to write, word 0 in the low bits |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | $clog2(DEPTH) | Line address of the response |
| rsp_data | output | WORD_W*LINE_WORDS | Line content of the response |

## Verification
Every result is due a fixed count of edges after the accepting edge. For a latency L, the write's reopened `cmd_ready` and the read's `rsp_valid` with its data appear after edge L. A drained response is gone one edge after it is taken. With zero latency, both results appear after the accepting edge itself. The bench drives inputs at falling edges. It counts edges from acceptance and samples every output at the falling edge that follows each rising edge. In each intermediate cycle it checks that nothing has been produced yet, and in the due cycle it checks the exact values.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

  // Bits needed to hold the countdown for a given latency (at least 1).
  function automatic int count_width(int lat);
    int w;
    w = 1;
    while ((1 << w) <= lat) w++;
    return w;
  endfunction

  // Value placed in the countdown at acceptance; the acceptance cycle
  // itself already counts as the first latency cycle.
  function automatic int load_value(int lat);
    return (lat == 0) ? 0 : lat - 1;
  endfunction

endpackage

// File: rtl/lmem_store.sv
module lmem_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int LW    = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [LW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [LW-1:0] rdata
);

  logic [LW-1:0] lines [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) lines[i] <= '0;
    end else if (we) begin
      lines[waddr] <= wdata;
    end
  end

  assign rdata = lines[raddr];

endmodule

// File: rtl/lmem_seq.sv
module lmem_seq #(
  parameter int AW      = 4,
  parameter int LW      = 128,
  parameter int LATENCY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_wdata,
  input  logic          rsp_space,
  output logic          cmd_ready,
  output logic          accept,
  output logic          counting,
  output logic          fire,
  output logic          cur_write,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] cur_data
);

  localparam int CW = lmem_pkg::count_width(LATENCY);
  localparam logic [CW-1:0] LOAD = CW'(lmem_pkg::load_value(LATENCY));
  localparam bit ZERO_LAT = (LATENCY == 0);

  logic          busy;
  logic [CW-1:0] remain;
  logic          held_write;
  logic [AW-1:0] held_addr;
  logic [LW-1:0] held_data;
  logic          due;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;
  assign counting  = busy && (remain != '0);

  // Command being worked on: the held one, or the incoming one on the
  // zero-latency direct path.
  assign cur_write = busy ? held_write : cmd_write;
  assign cur_addr  = busy ? held_addr  : cmd_addr;
  assign cur_data  = busy ? held_data  : cmd_wdata;

  assign due  = (accept && ZERO_LAT) || (busy && (remain == '0));
  assign fire = due && (cur_write || rsp_space);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      remain     <= '0;
      held_write <= 1'b0;
      held_addr  <= '0;
      held_data  <= '0;
    end else if (accept) begin
      held_write <= cmd_write;
      held_addr  <= cmd_addr;
      held_data  <= cmd_wdata;
      remain     <= LOAD;
      busy       <= ZERO_LAT ? !fire : 1'b1;
    end else if (busy) begin
      if (remain != '0) remain <= remain - CW'(1);
      else if (fire)    busy   <= 1'b0;
    end
  end

  // R2: an accepted command that did not finish closes the channel
  assert_single_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !fire |=> !cmd_ready);

endmodule

// File: rtl/lmem_rsp.sv
module lmem_rsp #(
  parameter int AW = 4,
  parameter int LW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [LW-1:0] rsp_data,
  output logic          space
);

  assign space = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= load_addr;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R5: never overwrite a response the consumer has not taken
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(rsp_valid && !rsp_ready));

  // R5: a stalled response holds its content
  assert_stall_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_addr));

  // R8: a taken response leaves unless replaced
  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !load |=> !rsp_valid);

endmodule

// File: rtl/linemem_single.sv
module linemem_single #(
  parameter int DEPTH      = 16,
  parameter int LATENCY    = 3,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic                         cmd_write,
  input  logic [$clog2(DEPTH)-1:0]     cmd_addr,
  input  logic [WORD_W*LINE_WORDS-1:0] cmd_wdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [$clog2(DEPTH)-1:0]     rsp_addr,
  output logic [WORD_W*LINE_WORDS-1:0] rsp_data
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = WORD_W * LINE_WORDS;

  logic          accept, counting, fire, rsp_space;
  logic          cur_write;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] cur_data, line_rd;
  logic          mem_we, rsp_load;

  assign mem_we   = fire && cur_write;
  assign rsp_load = fire && !cur_write;

  lmem_seq #(.AW(AW), .LW(LW), .LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_space(rsp_space),
    .cmd_ready(cmd_ready), .accept(accept), .counting(counting), .fire(fire),
    .cur_write(cur_write), .cur_addr(cur_addr), .cur_data(cur_data)
  );

  lmem_store #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .waddr(cur_addr), .wdata(cur_data),
    .raddr(cur_addr), .rdata(line_rd)
  );

  lmem_rsp #(.AW(AW), .LW(LW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .load(rsp_load), .load_addr(cur_addr), .load_data(line_rd),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .space(rsp_space)
  );

  // R9: a running countdown produces nothing
  assert_quiet_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    counting |-> !mem_we && !rsp_load);

  // R1: without a held command the channel is open next cycle unless one is taken
  assert_open_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && cmd_ready |=> cmd_ready);

endmodule

// File: tb/linemem_single_test.sv
`timescale 1ns/1ps
module linemem_single_test;

  localparam int DEPTH = 16;
  localparam int LAT   = 3;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cmd_valid = 0, cmd_write = 0, rsp_ready = 1;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_wdata = '0;
  logic          cmd_ready, rsp_valid;
  logic [AW-1:0] rsp_addr;
  logic [LW-1:0] rsp_data;

  logic          z_valid = 0, z_write = 0, z_rready = 1;
  logic [AW-1:0] z_addr = '0;
  logic [LW-1:0] z_wdata = '0;
  logic          z_ready, z_rvalid;
  logic [AW-1:0] z_raddr;
  logic [LW-1:0] z_rdata;

  linemem_single #(.DEPTH(DEPTH), .LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data));

  linemem_single #(.DEPTH(DEPTH), .LATENCY(0)) uut_z (
    .clk(clk), .rst_n(rst_n), .cmd_valid(z_valid), .cmd_ready(z_ready),
    .cmd_write(z_write), .cmd_addr(z_addr), .cmd_wdata(z_wdata),
    .rsp_valid(z_rvalid), .rsp_ready(z_rready), .rsp_addr(z_raddr),
    .rsp_data(z_rdata));

  int checks = 0, failures = 0;
  logic [LW-1:0] model [DEPTH];

  task automatic chk(bit ok, string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = $urandom;
    return l;
  endfunction

  // Edges from acceptance to completion for a given latency.
  function automatic int due_edges(int lat);
    return lat;
  endfunction

  // Starts at a falling edge; returns at the falling edge after completion
  // (or, with drain set, one edge later).
  task automatic issue(bit wr, logic [AW-1:0] a, logic [LW-1:0] d, bit drain);
    chk(cmd_ready === 1'b1, "R1 ready before command", LW'(cmd_ready), LW'(1));
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    for (int k = 0; k < due_edges(LAT); k++) begin
      chk(cmd_ready === 1'b0, "R2 ready low while held", LW'(cmd_ready), LW'(0));
      chk(rsp_valid === 1'b0, "R9 no output during countdown", LW'(rsp_valid), LW'(0));
      @(negedge clk);
    end
    if (wr) begin
      model[a] = d;
      chk(cmd_ready === 1'b1, "R3 write done", LW'(cmd_ready), LW'(1));
      chk(rsp_valid === 1'b0, "R3 write no response", LW'(rsp_valid), LW'(0));
    end else begin
      chk(rsp_valid === 1'b1, "R4 read valid", LW'(rsp_valid), LW'(1));
      chk(rsp_data === model[a], "R4 read data", rsp_data, model[a]);
      chk(rsp_addr === a, "R4 read addr", LW'(rsp_addr), LW'(a));
      if (drain) begin
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R8 response drained", LW'(rsp_valid), LW'(0));
      end
    end
  endtask

  initial begin
    repeat (2000 + 200 * (LAT + 3)) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [LW-1:0] la, lb;
    void'($urandom(32'd12345));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b1, "R1 reset ready", LW'(cmd_ready), LW'(1));
    chk(rsp_valid === 1'b0, "R1 reset no response", LW'(rsp_valid), LW'(0));
    rst_n = 1;
    @(negedge clk);

    // R6: untouched lines, including both ends
    issue(0, '0, '0, 1);
    issue(0, AW'(DEPTH - 1), '0, 1);
    chk(rsp_data === '0, "R6 unwritten reads zero", rsp_data, '0);

    // R3/R4 directed: top line written then read
    la = rand_line();
    issue(1, AW'(DEPTH - 1), la, 0);
    issue(0, AW'(DEPTH - 1), '0, 1);

    // R5: stall with a second read waiting behind the first
    la = rand_line(); lb = rand_line();
    issue(1, 4'd3, la, 0);
    issue(1, 4'd4, lb, 0);
    rsp_ready = 0;
    issue(0, 4'd3, '0, 0);
    cmd_valid = 1; cmd_write = 0; cmd_addr = 4'd4;
    @(negedge clk);
    cmd_valid = 0;
    for (int k = 0; k < LAT + 3; k++) begin
      chk(rsp_valid === 1'b1 && rsp_data === la, "R5 stalled response stable", rsp_data, la);
      chk(cmd_ready === 1'b0, "R5 waiting read holds channel", LW'(cmd_ready), LW'(0));
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_data === lb, "R5 handover data", rsp_data, lb);
    chk(rsp_addr === 4'd4, "R5 handover addr", LW'(rsp_addr), LW'(4));
    chk(cmd_ready === 1'b1, "R5 channel reopens", LW'(cmd_ready), LW'(1));
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R8 drained after handover", LW'(rsp_valid), LW'(0));

    // Random mix
    for (int n = 0; n < 150; n++) begin
      bit wr;
      logic [AW-1:0] a;
      wr = $urandom_range(0, 1) == 1;
      a  = AW'($urandom_range(0, DEPTH - 1));
      issue(wr, a, rand_line(), 1);
    end

    // R7: zero latency instance
    la = rand_line();
    z_valid = 1; z_write = 1; z_addr = 4'd2; z_wdata = la;
    chk(z_ready === 1'b1, "R7 zero-lat ready", LW'(z_ready), LW'(1));
    @(negedge clk);
    z_valid = 0;
    chk(z_ready === 1'b1, "R7 zero-lat write done at accept", LW'(z_ready), LW'(1));
    chk(z_rvalid === 1'b0, "R7 zero-lat write no response", LW'(z_rvalid), LW'(0));
    z_valid = 1; z_write = 0; z_addr = 4'd2;
    @(negedge clk);
    z_valid = 0;
    chk(z_rvalid === 1'b1 && z_rdata === la, "R7 zero-lat read data", z_rdata, la);
    chk(z_raddr === 4'd2, "R7 zero-lat read addr", LW'(z_raddr), LW'(2));
    chk(z_ready === 1'b1, "R7 zero-lat ready after read", LW'(z_ready), LW'(1));
    z_valid = 1; z_write = 0; z_addr = 4'd9;
    @(negedge clk);
    z_valid = 0;
    chk(z_rvalid === 1'b1 && z_rdata === '0, "R6 zero-lat unwritten", z_rdata, '0);
    @(negedge clk);
    chk(z_rvalid === 1'b0, "R8 zero-lat drained", LW'(z_rvalid), LW'(0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule